// File: doc/BRIEF.md
# SDRAM Command-Mode Access Injector

This block sits in front of an SDRAM controller's normal read/write engine and lets software drive the memory device's bring-up directly. A small control register holds a 3-bit command mode. While the mode is "normal", host memory accesses go unchanged to the normal path. In any other mode, each host access is turned into the SDRAM command that the mode names, whatever the access type. That command goes on the command bus for one clock. This is how software steps the device through initialisation and how it enters and leaves deep power-down.

A mode written to the register does not act at once. It is staged, and it takes effect on the first memory write access after the register write. The block also keeps a flag that records whether all banks have been precharged since the last row activation. It refuses an auto-refresh request while that flag is clear and signals an error instead.

Top module: `sdram_cmd_injector`

## Requirements
- R1: After reset, the register reads zero, the command bus shows NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111, bank and address zero), clock enable is high, and no acknowledge or error is driven.
- R2: A register write stores bits 2:0 of the write data as the mode, and the other bits of the read value are zero. A write is ignored while `reg_wp` is high. The read value is always available on `reg_rdata`.
- R3: A newly written mode applies from the first write access after the register write. Read accesses before that write still use the previous mode.
- R4: In mode 0, an access is forwarded combinationally on the `fwd_*` port. It is acknowledged in the cycle `fwd_ready` is high, and no command is issued.
- R5: Mode 1 issues NOP (0111), mode 2 issues precharge-all (0010), mode 3 issues load-mode (0000), mode 5 issues extended load-mode (0000), and mode 7 issues NOP. Each command appears in the cycle after acceptance, together with `acc_ack`.
- R6: Precharge-all drives address bit 10 high and all other address and bank bits low. Load-mode and extended load-mode copy `acc_bank` to the bank output and `acc_addr` to the address output. All other commands drive bank and address zero.
- R7: In mode 4, auto-refresh (0001) is issued only when the precharged flag is set. Otherwise the access is acknowledged with NOP, and `refresh_err` pulses for that one cycle.
- R8: The precharged flag is clear after reset. A precharge-all sets it, and a forwarded mode-0 access (treated as a row activation) clears it when the normal path accepts that access.
- R9: In mode 6, an access issues deep power-down (0110) with `sd_cke` low in the same cycle. Clock enable then stays low. Accesses that still see mode 6 are acknowledged with NOP.
- R10: While powered down, an access that sees a mode other than 6 first causes one cycle with clock enable high, a NOP, and no acknowledge. It is then handled in the new mode.
- R11: Each accepted injected access produces exactly one command cycle, followed by at least one NOP cycle, during which no new access is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_wp | input | 1 | Write-protect enable; blocks register writes |
| reg_rdata | output | REG_W | Register read value |
| acc_valid | input | 1 | Host memory access request |
| acc_write | input | 1 | Access is a write |
| acc_bank | input | BA_W | Access bank field |
| acc_addr | input | ADDR_W | Access row/column address |
| acc_ack | output | 1 | Access completed |
| fwd_valid | output | 1 | Forwarded request to the normal path |
| fwd_write | output | 1 | Forwarded access type |
| fwd_bank | output | BA_W | Forwarded bank |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_ready | input | 1 | Normal path accepts the request |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_ba | output | BA_W | Command bank address |
| sd_addr | output | ADDR_W | Command address |
| refresh_err | output | 1 | Refused refresh pulse |

## Verification
The bench targets the delayed activation of a new mode. A design that applied the mode at the register write would issue a precharge on a read access that should still be forwarded. It also drives a refresh both after a precharge and after a forwarded access has cleared the flag. A wrong flag would issue an illegal refresh or refuse a legal one. Deep power-down is entered, held across idle cycles and across accesses that still see mode 6, and then left by a write after the mode change. A design that skipped the wake-up cycle, or raised clock enable early, differs from the model on the cycle-by-cycle compare. A stalled normal path checks that the acknowledge waits for `fwd_ready`, and back-to-back accesses check that every command is followed by a NOP.

// File: rtl/cmi_pkg.sv
// Package: shared types and command codes for the command-mode injector.
// Assumes command bus order {cs_n, ras_n, cas_n, we_n}.
package cmi_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_NORMAL  = 3'd0,
        MD_NOP     = 3'd1,
        MD_PREALL  = 3'd2,
        MD_LOADMR  = 3'd3,
        MD_REFRESH = 3'd4,
        MD_EXTMR   = 3'd5,
        MD_DEEPPD  = 3'd6,
        MD_RSVD    = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAKE  = 2'd2
    } seq_state_e;

    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_LMR = 4'b0000;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_DPD = 4'b0110;

endpackage

// File: rtl/cmi_mode_regs.sv
// Module: cmi_mode_regs
// Holds the staged mode written by software and the active mode used for
// accesses. A staged mode becomes active when the sequencer signals that a
// write access consumed it. Assumes wr_lock is a level that blocks writes.
module cmi_mode_regs
    import cmi_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [REG_W-1:0] wr_data,
    input  logic             wr_lock,
    input  logic             access_write,
    input  logic             consume,
    output mode_e            eff_mode,
    output logic [REG_W-1:0] rd_data
);

    localparam int PAD_W = REG_W - MODE_W;

    mode_e staged_q;
    mode_e active_q;
    logic  pending_q;
    logic  wr_ok;

    assign wr_ok = wr_req && !wr_lock;

    // Stage register writes and promote the staged mode when consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q  <= MD_NORMAL;
            active_q  <= MD_NORMAL;
            pending_q <= 1'b0;
        end else begin
            if (consume) begin
                active_q  <= staged_q;
                pending_q <= 1'b0;
            end
            if (wr_ok) begin
                staged_q  <= mode_e'(wr_data[MODE_W-1:0]);
                pending_q <= 1'b1;
            end
        end
    end

    // Mode seen by the current access: a pending mode only for writes.
    always_comb begin
        eff_mode = (pending_q && access_write) ? staged_q : active_q;
    end

    // Read view: mode in the low bits, zeros above.
    assign rd_data = {{PAD_W{1'b0}}, staged_q};

    p_locked_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_lock) |=> $stable(rd_data));

    p_unlocked_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (rd_data[MODE_W-1:0] == $past(wr_data[MODE_W-1:0])));

    p_read_keeps_old_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !access_write) |-> (eff_mode == active_q));

endmodule

// File: rtl/cmi_refresh_guard.sv
// Module: cmi_refresh_guard
// Tracks whether all banks have been precharged since the last row
// activation. Assumes set and clear never arrive in the same cycle.
module cmi_refresh_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic pre_issued,
    input  logic row_opened,
    output logic precharged
);

    logic flag_q;

    // Set on precharge-all, clear on a forwarded activation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (pre_issued) begin
            flag_q <= 1'b1;
        end else if (row_opened) begin
            flag_q <= 1'b0;
        end
    end

    assign precharged = flag_q;

    p_set_clear_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pre_issued && row_opened));

    p_flag_follows_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_issued |=> precharged);

    p_flag_follows_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        row_opened |=> !precharged);

endmodule

// File: rtl/cmi_cmd_seq.sv
// Module: cmi_cmd_seq
// Accepts host accesses. In normal mode it forwards them; otherwise it
// issues the selected SDRAM command for one cycle, then NOP. It also handles
// deep power-down entry and the wake-up cycle. Assumes the host holds
// acc_valid stable until acc_ack.
module cmi_cmd_seq
    import cmi_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int BA_W    = 2,
    parameter int PRE_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [BA_W-1:0]   acc_bank,
    input  logic [ADDR_W-1:0] acc_addr,
    input  mode_e             eff_mode,
    input  logic              pre_ok,
    input  logic              fwd_ready,
    output logic              fwd_valid,
    output logic              acc_ack,
    output logic [3:0]        cmd,
    output logic [BA_W-1:0]   cmd_ba,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cke,
    output logic              refresh_err,
    output logic              consume,
    output logic              pre_set,
    output logic              row_open
);

    localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << PRE_BIT;

    seq_state_e        state_q, state_d;
    logic              dpd_q, dpd_d;
    logic [3:0]        cmd_q, cmd_d;
    logic [BA_W-1:0]   ba_q, ba_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              cke_q, cke_d;
    logic              ack_q, ack_d;
    logic              err_q, err_d;

    logic idle, inject_take, wake_take, dpd_hold, fwd_hs;

    // Classify the access offered in this cycle.
    always_comb begin
        idle        = (state_q == ST_IDLE);
        inject_take = idle && acc_valid && !dpd_q && (eff_mode != MD_NORMAL);
        wake_take   = idle && acc_valid && dpd_q && (eff_mode != MD_DEEPPD);
        dpd_hold    = idle && acc_valid && dpd_q && (eff_mode == MD_DEEPPD);
        fwd_valid   = idle && acc_valid && !dpd_q && (eff_mode == MD_NORMAL);
        fwd_hs      = fwd_valid && fwd_ready;
    end

    assign consume  = acc_write && (inject_take || wake_take || fwd_hs);
    assign pre_set  = inject_take && (eff_mode == MD_PREALL);
    assign row_open = fwd_hs;

    // Choose the next command bus contents and sequencer state.
    always_comb begin
        state_d = ST_IDLE;
        dpd_d   = dpd_q;
        cmd_d   = CMD_NOP;
        ba_d    = '0;
        addr_d  = '0;
        cke_d   = cke_q;
        ack_d   = 1'b0;
        err_d   = 1'b0;
        if (wake_take) begin
            state_d = ST_WAKE;
            dpd_d   = 1'b0;
            cke_d   = 1'b1;
        end else if (dpd_hold) begin
            ack_d   = 1'b1;
        end else if (inject_take) begin
            state_d = ST_ISSUE;
            ack_d   = 1'b1;
            unique case (eff_mode)
                MD_PREALL: begin
                    cmd_d  = CMD_PRE;
                    addr_d = PRE_ADDR;
                end
                MD_LOADMR, MD_EXTMR: begin
                    cmd_d  = CMD_LMR;
                    ba_d   = acc_bank;
                    addr_d = acc_addr;
                end
                MD_REFRESH: begin
                    if (pre_ok) begin
                        cmd_d = CMD_REF;
                    end else begin
                        err_d = 1'b1;
                    end
                end
                MD_DEEPPD: begin
                    cmd_d = CMD_DPD;
                    cke_d = 1'b0;
                    dpd_d = 1'b1;
                end
                default: cmd_d = CMD_NOP;
            endcase
        end
    end

    // Register the command bus, acknowledge and state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dpd_q   <= 1'b0;
            cmd_q   <= CMD_NOP;
            ba_q    <= '0;
            addr_q  <= '0;
            cke_q   <= 1'b1;
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            dpd_q   <= dpd_d;
            cmd_q   <= cmd_d;
            ba_q    <= ba_d;
            addr_q  <= addr_d;
            cke_q   <= cke_d;
            ack_q   <= ack_d;
            err_q   <= err_d;
        end
    end

    assign acc_ack     = ack_q || fwd_hs;
    assign cmd         = cmd_q;
    assign cmd_ba      = ba_q;
    assign cmd_addr    = addr_q;
    assign cke         = cke_q;
    assign refresh_err = err_q;

    p_cmd_then_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP));

    p_no_accept_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> !fwd_valid);

    p_refresh_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_REF) |-> $past(pre_ok));

    p_err_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q);

    p_forward_is_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (cmd_q == CMD_NOP) && cke_q);

    p_wake_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE) |-> (cke_q && !acc_ack && (cmd_q == CMD_NOP)));

    p_dpd_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_DPD) |-> !cke_q);

endmodule

// File: rtl/sdram_cmd_injector.sv
// Module: sdram_cmd_injector
// Top level: a write-protectable mode register, a precharge tracker and a
// command sequencer that turns host accesses into SDRAM commands or forwards
// them to the normal path. Assumes a single clock and synchronous reset.
module sdram_cmd_injector
    import cmi_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int ADDR_W  = 13,
    parameter int BA_W    = 2,
    parameter int PRE_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_wp,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [BA_W-1:0]   acc_bank,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_ack,
    output logic              fwd_valid,
    output logic              fwd_write,
    output logic [BA_W-1:0]   fwd_bank,
    output logic [ADDR_W-1:0] fwd_addr,
    input  logic              fwd_ready,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic              sd_cke,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              refresh_err
);

    mode_e      eff_mode;
    logic       consume, pre_set, row_open, precharged;
    logic [3:0] cmd;

    cmi_mode_regs #(.REG_W(REG_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_req       (reg_wr),
        .wr_data      (reg_wdata),
        .wr_lock      (reg_wp),
        .access_write (acc_write),
        .consume      (consume),
        .eff_mode     (eff_mode),
        .rd_data      (reg_rdata)
    );

    cmi_refresh_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_issued (pre_set),
        .row_opened (row_open),
        .precharged (precharged)
    );

    cmi_cmd_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .PRE_BIT(PRE_BIT)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .acc_bank    (acc_bank),
        .acc_addr    (acc_addr),
        .eff_mode    (eff_mode),
        .pre_ok      (precharged),
        .fwd_ready   (fwd_ready),
        .fwd_valid   (fwd_valid),
        .acc_ack     (acc_ack),
        .cmd         (cmd),
        .cmd_ba      (sd_ba),
        .cmd_addr    (sd_addr),
        .cke         (sd_cke),
        .refresh_err (refresh_err),
        .consume     (consume),
        .pre_set     (pre_set),
        .row_open    (row_open)
    );

    // Pass the access fields straight through to the normal path.
    assign fwd_write = acc_write;
    assign fwd_bank  = acc_bank;
    assign fwd_addr  = acc_addr;

    // Split the command code onto the individual strobes.
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    p_powered_down_no_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cke && $past(!sd_cke)) |-> !fwd_valid);

    p_precharge_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> (sd_addr[PRE_BIT] && ($countones(sd_addr) == 1) && (sd_ba == '0)));

endmodule

// File: tb/sim_sdram_cmd_injector.sv
`timescale 1ns/1ps
module sim_sdram_cmd_injector;

    localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, LMR = 4'b0000,
                           REF = 4'b0001, DPD = 4'b0110;

    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0, reg_wp = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        acc_valid = 0, acc_write = 0, acc_ack;
    logic [1:0]  acc_bank = 0, fwd_bank, sd_ba;
    logic [12:0] acc_addr = 0, fwd_addr, sd_addr;
    logic        fwd_valid, fwd_write, fwd_ready = 1;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, refresh_err;

    int n_chk = 0, n_fail = 0;
    bit chk_on = 0, done = 0;

    // Reference model state
    int         m_staged, m_act, m_pend, m_flag, m_state, m_dpd;
    logic [3:0] m_cmd;
    logic [1:0] m_ba;
    logic [12:0] m_addr;
    logic       m_cke, m_ack, m_err;
    int         eff;
    bit         take;

    sdram_cmd_injector u0 (.*);

    always #2.5 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_staged = 0; m_act = 0; m_pend = 0; m_flag = 0; m_state = 0; m_dpd = 0;
            m_cmd = NOP; m_ba = 0; m_addr = 0; m_cke = 1; m_ack = 0; m_err = 0;
        end else begin
            eff = (m_pend != 0 && acc_write) ? m_staged : m_act;
            take = 0;
            m_cmd = NOP; m_ba = 0; m_addr = 0; m_ack = 0; m_err = 0;
            if (m_state != 0) m_state = 0;
            else if (acc_valid) begin
                if (m_dpd != 0) begin
                    if (eff != 6) begin m_state = 2; m_cke = 1; m_dpd = 0; take = 1; end
                    else m_ack = 1;
                end else if (eff == 0) begin
                    if (fwd_ready) begin m_flag = 0; take = 1; end
                end else begin
                    m_state = 1; m_ack = 1; take = 1;
                    case (eff)
                        2: begin m_cmd = PRE; m_addr = 13'd1 << 10; m_flag = 1; end
                        3, 5: begin m_cmd = LMR; m_ba = acc_bank; m_addr = acc_addr; end
                        4: if (m_flag != 0) m_cmd = REF; else m_err = 1;
                        6: begin m_cmd = DPD; m_cke = 0; m_dpd = 1; end
                        default: m_cmd = NOP;
                    endcase
                end
            end
            if (take && acc_write) begin m_act = m_staged; m_pend = 0; end
            if (reg_wr && !reg_wp) begin m_staged = int'(reg_wdata[2:0]); m_pend = 1; end
        end
    end

    // Compare every output with the model between edges
    always @(negedge clk) begin
        if (chk_on) begin
            int  ef;
            logic efwd;
            ef   = (m_pend != 0 && acc_write) ? m_staged : m_act;
            efwd = acc_valid && m_state == 0 && m_dpd == 0 && ef == 0;
            chk("R5 cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, m_cmd);
            chk("R6 ba", sd_ba, m_ba);
            chk("R6 addr", sd_addr, m_addr);
            chk("R9 cke", sd_cke, m_cke);
            chk("R7 err", refresh_err, m_err);
            chk("R4 fwd_valid", fwd_valid, efwd);
            chk("R11 ack", acc_ack, m_ack || (efwd && fwd_ready));
            chk("R2 rdata", reg_rdata, m_staged);
        end
    end

    task automatic reg_write(input logic [31:0] d, input logic wp);
        @(posedge clk); #1;
        reg_wr = 1; reg_wdata = d; reg_wp = wp;
        @(posedge clk); #1;
        reg_wr = 0; reg_wp = 0;
    endtask

    task automatic do_acc(input logic w, input logic [1:0] b, input logic [12:0] a,
                          output logic [3:0] c, output logic k, output logic e,
                          output logic [1:0] ob, output logic [12:0] oa);
        @(posedge clk); #1;
        acc_valid = 1; acc_write = w; acc_bank = b; acc_addr = a;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (acc_ack) break;
        end
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}; k = sd_cke; e = refresh_err;
        ob = sd_ba; oa = sd_addr;
        @(posedge clk); #1;
        acc_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] c; logic k, e; logic [1:0] ob; logic [12:0] oa;
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        @(negedge clk);
        chk("R1 rdata", reg_rdata, 0);
        chk("R1 cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, NOP);
        chk("R1 cke", sd_cke, 1);
        chk("R1 ack", acc_ack, 0);
        chk_on = 1;

        reg_write(32'hFFFF_FFFD, 0);
        @(negedge clk); chk("R2 masked read", reg_rdata, 5);
        reg_write(32'h2, 1);
        @(negedge clk); chk("R2 protected", reg_rdata, 5);

        reg_write(32'h2, 0);
        do_acc(0, 0, 13'h5, c, k, e, ob, oa);
        chk("R3 read keeps old mode", c, NOP);
        do_acc(1, 3, 13'h1FF, c, k, e, ob, oa);
        chk("R5 precharge", c, PRE);
        chk("R6 precharge addr", oa, 13'h400);
        chk("R6 precharge bank", ob, 0);
        do_acc(0, 0, 0, c, k, e, ob, oa);
        chk("R3 mode now active", c, PRE);

        reg_write(32'h4, 0);
        do_acc(1, 0, 0, c, k, e, ob, oa);
        chk("R7 refresh allowed", c, REF);
        chk("R8 flag set", e, 0);

        reg_write(32'h0, 0);
        do_acc(1, 1, 13'h22, c, k, e, ob, oa);
        reg_write(32'h4, 0);
        do_acc(1, 0, 0, c, k, e, ob, oa);
        chk("R8 flag cleared", c, NOP);
        chk("R7 refused refresh", e, 1);

        reg_write(32'h3, 0);
        do_acc(1, 2, 13'h033, c, k, e, ob, oa);
        chk("R5 load mode", c, LMR);
        chk("R6 load bank", ob, 2);
        chk("R6 load addr", oa, 13'h033);
        reg_write(32'h5, 0);
        do_acc(1, 1, 13'h0402, c, k, e, ob, oa);
        chk("R6 ext bank", ob, 1);
        chk("R6 ext addr", oa, 13'h0402);
        reg_write(32'h1, 0);
        do_acc(1, 0, 0, c, k, e, ob, oa);
        chk("R5 nop", c, NOP);
        reg_write(32'h7, 0);
        do_acc(1, 0, 0, c, k, e, ob, oa);
        chk("R5 reserved nop", c, NOP);

        reg_write(32'h0, 0);
        fwd_ready = 0;
        fork
            do_acc(1, 0, 13'h10, c, k, e, ob, oa);
            begin repeat (4) @(posedge clk); #1; fwd_ready = 1; end
        join
        chk("R4 forwarded", c, NOP);

        reg_write(32'h6, 0);
        do_acc(1, 0, 0, c, k, e, ob, oa);
        chk("R9 deep cmd", c, DPD);
        chk("R9 cke low", k, 0);
        repeat (5) @(posedge clk);
        @(negedge clk); chk("R9 cke held", sd_cke, 0);
        do_acc(0, 0, 0, c, k, e, ob, oa);
        chk("R9 hold nop", c, NOP);
        chk("R9 still low", k, 0);
        reg_write(32'h1, 0);
        do_acc(0, 0, 0, c, k, e, ob, oa);
        chk("R10 read no wake", k, 0);
        do_acc(1, 0, 0, c, k, e, ob, oa);
        chk("R10 woken cke", k, 1);
        chk("R10 woken nop", c, NOP);

        reg_write(32'h2, 0);
        @(posedge clk); #1;
        acc_valid = 1; acc_write = 1;
        repeat (6) @(posedge clk);
        #1; acc_valid = 0;
        repeat (3) @(posedge clk);

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule